// File: doc/BRIEF.md
# ATM Idle Cell Filter

This block sits in the receive path of an ATM cell stream that carries one byte per valid cycle. For every cell it decides whether the cell is an idle cell. It makes that decision by comparing the four header bytes, bit by bit, against four programmable pattern bytes. Four mask bytes select which bits take part: a mask bit of 1 compares that bit, and a mask bit of 0 ignores it. A cell is idle only when every compared bit of all four header bytes agrees with the pattern.

A configuration register holds a discard bit. When the bit is set, idle cells are removed from the stream in full. When it is clear, every cell passes unchanged towards the downstream user-cell filter. The block holds the first four bytes of each cell until the decision is known, so the output lags the input by four valid bytes. The block raises a one-cycle pulse for each idle cell it detects, and a saturating counter records how many cells it has dropped. Register writes are staged: a new setting takes effect at the next start of cell, so a cell is never judged by a mix of old and new settings.

The sequencer has three states. ST_HUNT waits for a start-of-cell byte. ST_HDR collects header bytes 2 to 4. ST_BODY passes bytes 5 to 53. The transitions are: ST_HUNT to ST_HDR on a start-of-cell byte; ST_HDR to ST_BODY on the last header byte, which is where the decision is made; ST_BODY to ST_HUNT on byte 53. Any state goes to ST_HDR when a start-of-cell byte arrives.

Top module: `idle_cell_filter`

## Requirements
- R1: After reset, out_valid and idle_match are 0, discard_count is 0, and every mapped register reads 0.
- R2: The configuration register sits at address 4Ch. Pattern bytes for header bytes 1 to 4 sit at 50h to 53h, and mask bytes at 54h to 57h. Each one reads back what was last written. Bit 7 of the configuration register always reads 0. Any unmapped address reads 0.
- R3: A cell is idle exactly when ((header byte i XOR pattern i) AND mask i) is 0 for all four header bytes. A single differing bit in a masked position of any byte makes the cell non-idle. A differing bit where the mask is 0 has no effect.
- R4: When bit 4 of 4Ch (discard) is 1, an idle cell produces no out_valid on any of its 53 bytes, and discard_count increases by one.
- R5: When the discard bit is 0, idle cells are forwarded like any other cell and discard_count is unchanged. Bits 0 to 3, 5 and 6 of 4Ch have no effect on filtering.
- R6: A forwarded cell leaves with all 53 bytes in order and unchanged. out_soc is 1 on its first byte only.
- R7: Output byte k of a cell is presented in the cycle after the fourth valid byte that follows it is accepted. For the first byte of a cell, that is the cycle after byte 5 of the same cell is accepted.
- R8: idle_match is a one-cycle pulse for each idle cell, whatever the discard setting. It is raised in the cycle after that cell's fourth header byte is accepted.
- R9: discard_count saturates at its all-ones value.
- R10: A register write accepted after a cell's first byte does not change that cell's decision. It applies from the next start-of-cell byte.
- R11: Valid bytes that arrive outside a cell (no start-of-cell byte since the last cell ended) are never forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_soc | input | 1 | Input byte is the first byte of a cell |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_soc | output | 1 | Output byte is the first byte of a cell |
| out_data | output | 8 | Output byte |
| idle_match | output | 1 | One-cycle pulse per detected idle cell |
| discard_count | output | CNT_W (16) | Saturating count of dropped cells |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |

## Verification
The bench sends headers that differ from the pattern by one bit, in a masked position and then in an unmasked one, in different header bytes. A design that compared all bits, or only some of the bytes, would forward or drop the wrong cell. It writes the pattern and the discard bit while a cell's header is still arriving, and checks that this cell follows the old settings and the next cell follows the new ones; a design without staging would change its decision part-way through a cell. It checks the exact cycle of the first output byte and of the match pulse, so a pipeline that is one stage too long or too short shows up. It also feeds bytes outside any cell, and drives the counter past its saturation value with a narrowed counter: a design that let those bytes through would emit extra bytes, and a counter that wrapped would read a small value instead of all ones.

// File: rtl/idf_pkg.sv
package idf_pkg;
    typedef enum logic [1:0] {
        ST_HUNT,
        ST_HDR,
        ST_BODY
    } seq_state_t;

    typedef struct packed {
        logic       v;
        logic       drop;
        logic       soc;
        logic [7:0] data;
    } lane_t;

    localparam logic [7:0] ADDR_CFG  = 8'h4C;
    localparam logic [7:0] ADDR_PAT0 = 8'h50;
    localparam int         DISC_BIT  = 4;
endpackage

// File: rtl/idf_regs.sv
module idf_regs
    import idf_pkg::*;
#(
    parameter int HDR_BYTES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_we,
    input  logic [7:0]                reg_addr,
    input  logic [7:0]                reg_wdata,
    input  logic                      load,
    output logic [7:0]                reg_rdata,
    output logic [HDR_BYTES-1:0][7:0] eff_pat,
    output logic [HDR_BYTES-1:0][7:0] eff_msk,
    output logic                      eff_disc
);
    logic [6:0]                cfg_q;
    logic [HDR_BYTES-1:0][7:0] pat_q, msk_q, act_pat, act_msk;
    logic                      act_disc;
    logic [HDR_BYTES-1:0]      pat_hit, msk_hit;
    logic                      cfg_hit;

    assign cfg_hit = reg_we && (reg_addr == ADDR_CFG);

    for (genvar g = 0; g < HDR_BYTES; g++) begin : g_dec
        assign pat_hit[g] = reg_we && (reg_addr == ADDR_PAT0 + 8'(g));
        assign msk_hit[g] = reg_we && (reg_addr == ADDR_PAT0 + 8'(HDR_BYTES) + 8'(g));
    end

    // live copies, visible to readback
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            pat_q <= '0;
            msk_q <= '0;
        end else begin
            if (cfg_hit) cfg_q <= reg_wdata[6:0];
            for (int i = 0; i < HDR_BYTES; i++) begin
                if (pat_hit[i]) pat_q[i] <= reg_wdata;
                if (msk_hit[i]) msk_q[i] <= reg_wdata;
            end
        end
    end

    // active copies, refreshed only at a start-of-cell byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_pat  <= '0;
            act_msk  <= '0;
            act_disc <= 1'b0;
        end else if (load) begin
            act_pat  <= pat_q;
            act_msk  <= msk_q;
            act_disc <= cfg_q[DISC_BIT];
        end
    end

    assign eff_pat  = load ? pat_q : act_pat;
    assign eff_msk  = load ? msk_q : act_msk;
    assign eff_disc = load ? cfg_q[DISC_BIT] : act_disc;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_CFG) reg_rdata = {1'b0, cfg_q};
        for (int i = 0; i < HDR_BYTES; i++) begin
            if (reg_addr == ADDR_PAT0 + 8'(i)) reg_rdata = pat_q[i];
            if (reg_addr == ADDR_PAT0 + 8'(HDR_BYTES) + 8'(i)) reg_rdata = msk_q[i];
        end
    end

    // settings used for a cell stay fixed between start-of-cell bytes
    assert_act_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(act_pat) && $stable(act_msk) && $stable(act_disc)));
endmodule

// File: rtl/idf_match.sv
module idf_match #(
    parameter int HDR_BYTES = 4,
    localparam int IDX_W = $clog2(HDR_BYTES)
) (
    input  logic [7:0]                byte_in,
    input  logic [IDX_W-1:0]          hdr_idx,
    input  logic [HDR_BYTES-1:0][7:0] eff_pat,
    input  logic [HDR_BYTES-1:0][7:0] eff_msk,
    output logic                      byte_ok
);
    logic [7:0] diff;

    assign diff    = (byte_in ^ eff_pat[hdr_idx]) & eff_msk[hdr_idx];
    assign byte_ok = (diff == 8'h00);
endmodule

// File: rtl/idf_seq.sv
module idf_seq
    import idf_pkg::*;
#(
    parameter int CELL_BYTES = 53,
    parameter int HDR_BYTES  = 4,
    parameter int CNT_W      = 16,
    localparam int CW    = $clog2(CELL_BYTES + 1),
    localparam int IDX_W = $clog2(HDR_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_soc,
    input  logic             byte_ok,
    input  logic             eff_disc,
    output logic             load,
    output logic             in_cell,
    output logic             decide,
    output logic             drop_now,
    output logic [IDX_W-1:0] hdr_idx,
    output logic             idle_match,
    output logic [CNT_W-1:0] discard_count
);
    seq_state_t    state, state_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic          acc_q, acc_n;

    always_comb begin
        state_n = state;
        cnt_n   = cnt_q;
        acc_n   = acc_q;
        in_cell = 1'b0;
        decide  = 1'b0;
        hdr_idx = cnt_q[IDX_W-1:0];
        load    = in_valid && in_soc;
        if (in_valid) begin
            if (in_soc) begin
                hdr_idx = '0;
                in_cell = 1'b1;
                cnt_n   = CW'(1);
                acc_n   = byte_ok;
                state_n = ST_HDR;
            end else begin
                unique case (state)
                    ST_HUNT: begin
                        state_n = ST_HUNT;
                    end
                    ST_HDR: begin
                        in_cell = 1'b1;
                        cnt_n   = cnt_q + 1'b1;
                        acc_n   = acc_q & byte_ok;
                        if (cnt_q == CW'(HDR_BYTES - 1)) begin
                            decide  = 1'b1;
                            state_n = ST_BODY;
                        end
                    end
                    ST_BODY: begin
                        in_cell = 1'b1;
                        cnt_n   = cnt_q + 1'b1;
                        if (cnt_q == CW'(CELL_BYTES - 1)) state_n = ST_HUNT;
                    end
                    default: state_n = ST_HUNT;
                endcase
            end
        end
        drop_now = acc_n & eff_disc;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_HUNT;
            cnt_q <= '0;
            acc_q <= 1'b0;
        end else begin
            state <= state_n;
            cnt_q <= cnt_n;
            acc_q <= acc_n;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_match    <= 1'b0;
            discard_count <= '0;
        end else begin
            idle_match <= decide && acc_n;
            if (decide && drop_now && (discard_count != '1))
                discard_count <= discard_count + 1'b1;
        end
    end

    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        idle_match |=> !idle_match);

    assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (discard_count == '1) |=> (discard_count == '1));

    assert_count_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (discard_count != $past(discard_count)) |-> $past(decide && drop_now));
endmodule

// File: rtl/idf_pipe.sv
module idf_pipe
    import idf_pkg::*;
#(
    parameter int HDR_BYTES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_soc,
    input  logic [7:0] in_data,
    input  logic       in_cell,
    input  logic       decide,
    input  logic       drop_now,
    output logic       out_valid,
    output logic       out_soc,
    output logic [7:0] out_data
);
    lane_t lane_q [HDR_BYTES];
    lane_t lane_d [HDR_BYTES];
    logic  cur_drop, new_drop;

    assign new_drop = decide ? drop_now : (in_soc ? 1'b0 : cur_drop);

    for (genvar g = 0; g < HDR_BYTES; g++) begin : g_lane
        if (g == 0) begin : g_head
            always_comb begin
                lane_d[g].v    = in_cell;
                lane_d[g].drop = new_drop;
                lane_d[g].soc  = in_soc;
                lane_d[g].data = in_data;
            end
        end else begin : g_body
            always_comb begin
                lane_d[g] = lane_q[g-1];
                if (decide) lane_d[g].drop = drop_now;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < HDR_BYTES; i++) lane_q[i] <= '0;
            cur_drop  <= 1'b0;
            out_valid <= 1'b0;
            out_soc   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid && lane_q[HDR_BYTES-1].v && !lane_q[HDR_BYTES-1].drop;
            out_soc   <= in_valid && lane_q[HDR_BYTES-1].v && !lane_q[HDR_BYTES-1].drop
                         && lane_q[HDR_BYTES-1].soc;
            out_data  <= lane_q[HDR_BYTES-1].data;
            if (in_valid) begin
                for (int i = 0; i < HDR_BYTES; i++) lane_q[i] <= lane_d[i];
                if (in_soc || decide) cur_drop <= new_drop;
            end
        end
    end

    assert_out_needs_in_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    assert_soc_marks_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_soc |-> out_valid);
endmodule

// File: rtl/idle_cell_filter.sv
module idle_cell_filter
    import idf_pkg::*;
#(
    parameter int CELL_BYTES = 53,
    parameter int HDR_BYTES  = 4,
    parameter int CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_soc,
    input  logic [7:0]       in_data,
    output logic             out_valid,
    output logic             out_soc,
    output logic [7:0]       out_data,
    output logic             idle_match,
    output logic [CNT_W-1:0] discard_count,
    input  logic             reg_we,
    input  logic [7:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata
);
    localparam int IDX_W = $clog2(HDR_BYTES);

    logic [HDR_BYTES-1:0][7:0] eff_pat, eff_msk;
    logic                      eff_disc, load, in_cell, decide, drop_now, byte_ok;
    logic [IDX_W-1:0]          hdr_idx;

    idf_regs #(.HDR_BYTES(HDR_BYTES)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .load     (load),
        .reg_rdata(reg_rdata),
        .eff_pat  (eff_pat),
        .eff_msk  (eff_msk),
        .eff_disc (eff_disc)
    );

    idf_match #(.HDR_BYTES(HDR_BYTES)) u_match (
        .byte_in(in_data),
        .hdr_idx(hdr_idx),
        .eff_pat(eff_pat),
        .eff_msk(eff_msk),
        .byte_ok(byte_ok)
    );

    idf_seq #(
        .CELL_BYTES(CELL_BYTES),
        .HDR_BYTES (HDR_BYTES),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_soc       (in_soc),
        .byte_ok      (byte_ok),
        .eff_disc     (eff_disc),
        .load         (load),
        .in_cell      (in_cell),
        .decide       (decide),
        .drop_now     (drop_now),
        .hdr_idx      (hdr_idx),
        .idle_match   (idle_match),
        .discard_count(discard_count)
    );

    idf_pipe #(.HDR_BYTES(HDR_BYTES)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_soc   (in_soc),
        .in_data  (in_data),
        .in_cell  (in_cell),
        .decide   (decide),
        .drop_now (drop_now),
        .out_valid(out_valid),
        .out_soc  (out_soc),
        .out_data (out_data)
    );
endmodule

// File: tb/tb_idle_cell_filter.sv
module tb_idle_cell_filter;
    localparam int CW   = 3;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0, in_soc = 1'b0;
    logic [7:0]    in_data = '0;
    logic          out_valid, out_soc, idle_match;
    logic [7:0]    out_data, reg_rdata;
    logic [CW-1:0] discard_count;
    logic          reg_we = 1'b0;
    logic [7:0]    reg_addr = '0, reg_wdata = '0;

    always #10 clk = ~clk;

    idle_cell_filter #(.CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_soc(in_soc), .in_data(in_data),
        .out_valid(out_valid), .out_soc(out_soc), .out_data(out_data),
        .idle_match(idle_match), .discard_count(discard_count),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    int          total = 0, bad = 0;
    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [8:0]  exp_q [$];
    logic [8:0]  e_item;
    int          exp_idle = 0, seen_idle = 0, exp_disc = 0, out_cnt = 0;
    int unsigned soc_exp_cyc = 0, idle_exp_cyc = 0;
    logic [7:0]  m_pat [4], m_msk [4], s_pat [4], s_msk [4];
    logic [7:0]  m_cfg = '0;
    logic        s_disc;
    bit          done = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    function automatic bit calc_idle(input logic [31:0] hdr);
        for (int i = 0; i < 4; i++)
            if (((hdr[8*(3-i) +: 8] ^ s_pat[i]) & s_msk[i]) != 8'h00) return 1'b0;
        return 1'b1;
    endfunction

    task automatic mdl_wr(input logic [7:0] a, input logic [7:0] d);
        if (a == 8'h4C) m_cfg = {1'b0, d[6:0]};
        for (int i = 0; i < 4; i++) begin
            if (a == 8'h50 + 8'(i)) m_pat[i] = d;
            if (a == 8'h54 + 8'(i)) m_msk[i] = d;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #2;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        mdl_wr(a, d);
        @(posedge clk); #2;
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        @(posedge clk); #2;
        reg_addr = a;
        #3;
        chk(req, 32'(reg_rdata), 32'(exp));
    endtask

    task automatic send_cell(input logic [31:0] hdr, input int gap_pct,
                             input int wr_at, input logic [7:0] wa, input logic [7:0] wd);
        bit         idle, drop;
        logic [7:0] b;
        s_pat  = m_pat;
        s_msk  = m_msk;
        s_disc = m_cfg[4];
        idle   = calc_idle(hdr);
        drop   = idle && s_disc;
        if (idle) exp_idle++;
        if (drop && exp_disc < CMAX) exp_disc++;
        for (int k = 0; k < 53; k++) begin
            if (gap_pct > 0 && $urandom_range(99) < 32'(gap_pct)) begin
                @(posedge clk); #2;
                in_valid = 1'b0; in_soc = 1'b0; reg_we = 1'b0;
            end
            @(posedge clk); #2;
            b = (k < 4) ? hdr[8*(3-k) +: 8] : 8'($urandom);
            in_valid = 1'b1; in_soc = (k == 0); in_data = b;
            reg_we = (k == wr_at);
            if (k == wr_at) begin
                reg_addr = wa; reg_wdata = wd;
                mdl_wr(wa, wd);
            end
            if (!drop) exp_q.push_back({(k == 0), b});
            if (k == 4) soc_exp_cyc = cyc + 1;
            if (k == 3 && idle) idle_exp_cyc = cyc + 1;
        end
        @(posedge clk); #2;
        in_valid = 1'b0; in_soc = 1'b0; reg_we = 1'b0;
    endtask

    task automatic filler(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            in_valid = 1'b1; in_soc = 1'b0; in_data = 8'hA5;
        end
        @(posedge clk); #2;
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    // output monitor, sampled on the falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (idle_match) begin
                seen_idle++;
                chk("R8 pulse cycle", 32'(cyc), 32'(idle_exp_cyc));
            end
            if (out_valid) begin
                out_cnt++;
                if (exp_q.size() == 0) begin
                    chk("R11 unexpected output byte", 32'(1), 32'(0));
                end else begin
                    e_item = exp_q.pop_front();
                    chk("R6 byte and soc", 32'({out_soc, out_data}), 32'(e_item));
                    if (out_soc) chk("R7 first byte latency", 32'(cyc), 32'(soc_exp_cyc));
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk("R1 watchdog expired", 32'(1), 32'(0));
        summary();
    end

    initial begin
        int snap;
        logic [31:0] h;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) begin m_pat[i] = '0; m_msk[i] = '0; end
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid after reset", 32'(out_valid), 32'(0));
        chk("R1 idle_match after reset", 32'(idle_match), 32'(0));
        chk("R1 discard_count after reset", 32'(discard_count), 32'(0));
        rd_chk("R1 cfg after reset", 8'h4C, 8'h00);
        rd_chk("R1 pattern after reset", 8'h50, 8'h00);
        rd_chk("R1 mask after reset", 8'h57, 8'h00);

        // register map
        wr(8'h4C, 8'hFF);
        rd_chk("R2 cfg bit7 reads 0", 8'h4C, 8'h7F);
        for (int i = 0; i < 4; i++) begin
            wr(8'h50 + 8'(i), 8'h11 * 8'(i + 1));
            wr(8'h54 + 8'(i), 8'hC0 + 8'(i));
        end
        for (int i = 0; i < 4; i++) begin
            rd_chk("R2 pattern readback", 8'h50 + 8'(i), 8'h11 * 8'(i + 1));
            rd_chk("R2 mask readback", 8'h54 + 8'(i), 8'hC0 + 8'(i));
        end
        rd_chk("R2 unmapped 58h", 8'h58, 8'h00);
        rd_chk("R2 unmapped 4Bh", 8'h4B, 8'h00);

        // idle pattern 00 00 00 01, full masks, discard on
        for (int i = 0; i < 4; i++) begin
            wr(8'h50 + 8'(i), (i == 3) ? 8'h01 : 8'h00);
            wr(8'h54 + 8'(i), 8'hFF);
        end
        wr(8'h4C, 8'h10);
        send_cell(32'h00000001, 0, -1, 8'h00, 8'h00);
        chk("R4 idle cell dropped and counted", 32'(discard_count), 32'(1));
        chk("R8 pulse count", 32'(seen_idle), 32'(exp_idle));
        send_cell(32'h00000003, 0, -1, 8'h00, 8'h00);
        send_cell(32'h00800001, 0, -1, 8'h00, 8'h00);
        chk("R3 masked mismatch not counted", 32'(discard_count), 32'(1));
        wr(8'h55, 8'h7F);
        send_cell(32'h00800001, 0, -1, 8'h00, 8'h00);
        chk("R3 unmasked bit ignored", 32'(discard_count), 32'(2));

        // discard off, other config bits set
        wr(8'h4C, 8'hEF);
        send_cell(32'h00000001, 0, -1, 8'h00, 8'h00);
        chk("R5 idle cell kept, count unchanged", 32'(discard_count), 32'(2));
        chk("R5 pulse still raised", 32'(seen_idle), 32'(exp_idle));

        // writes during a header
        wr(8'h4C, 8'h10);
        send_cell(32'h00000001, 0, 1, 8'h53, 8'h02);
        chk("R10 old pattern used for current cell", 32'(discard_count), 32'(3));
        send_cell(32'h00000001, 0, -1, 8'h00, 8'h00);
        chk("R10 new pattern used for next cell", 32'(discard_count), 32'(3));
        send_cell(32'h00000002, 0, 2, 8'h4C, 8'h00);
        chk("R10 old discard bit used", 32'(discard_count), 32'(4));
        send_cell(32'h00000002, 0, -1, 8'h00, 8'h00);
        chk("R10 new discard bit used", 32'(discard_count), 32'(4));

        filler(4);
        chk("R6 all expected bytes seen", 32'(exp_q.size()), 32'(0));
        snap = out_cnt;
        filler(10);
        chk("R11 bytes outside a cell dropped", 32'(out_cnt), 32'(snap));

        // constrained random cells
        for (int c = 0; c < 40; c++) begin
            if (c % 8 == 0) begin
                for (int i = 0; i < 4; i++) begin
                    wr(8'h50 + 8'(i), 8'($urandom));
                    wr(8'h54 + 8'(i), 8'($urandom) | 8'h81);
                end
                wr(8'h4C, {1'b0, 7'($urandom)});
            end
            for (int i = 0; i < 4; i++) begin
                if ($urandom_range(1) == 0)
                    h[8*(3-i) +: 8] = (m_pat[i] & m_msk[i]) | (8'($urandom) & ~m_msk[i]);
                else
                    h[8*(3-i) +: 8] = 8'($urandom);
            end
            send_cell(h, 20, -1, 8'h00, 8'h00);
            chk("R4 random discard count", 32'(discard_count), 32'(exp_disc));
        end
        filler(4);
        chk("R6 random stream drained", 32'(exp_q.size()), 32'(0));
        chk("R8 random pulse count", 32'(seen_idle), 32'(exp_idle));

        // saturation: every cell idle, discard on
        for (int i = 0; i < 4; i++) wr(8'h54 + 8'(i), 8'h00);
        wr(8'h4C, 8'h10);
        for (int c = 0; c < CMAX + 2; c++) send_cell(32'(c * 7919), 0, -1, 8'h00, 8'h00);
        filler(4);
        chk("R9 counter saturated", 32'(discard_count), 32'(CMAX));
        chk("R9 model agrees", 32'(exp_disc), 32'(CMAX));
        chk("R4 dropped cells emit nothing", 32'(exp_q.size()), 32'(0));
        summary();
    end
endmodule